// File: doc/BRIEF.md
# Endpoint Test Function Controller

This block is a memory-mapped test device for exercising a host's view of an endpoint. The host reaches it through a small word-addressed register port. It can write any pattern to a scratch register and read it back to confirm that the address window decodes. It can also write a command word that starts one action. The action raises an interrupt, reads a host buffer, fills a host buffer with a known pattern, or copies one host buffer into another.

Transfers run over a single-outstanding request/response memory master, one 32-bit word at a time. Each finished action leaves per-operation success or fail flags in a status register. After a transfer or an explicit raise command, the block pulses an interrupt request. The request carries the kind and vector number that the host chose.

Register word indices (`reg_addr`): 0 scratch, 1 command, 2 status, 3 source address, 4 destination address, 5 transfer size in bytes, 6 interrupt kind, 7 interrupt vector.

Top module: `ept_ctrl`

## Requirements
- R1: The scratch register (index 0) returns on read exactly the 32-bit value last written to it.
- R2: Command bits (index 1) are: bit0 raise legacy, bit1 raise MSI, bit2 raise MSI-X, bit3 read buffer, bit4 fill buffer, bit5 copy buffer. When several bits are written together, only the lowest set bit is acted on. All three raise bits raise the interrupt that the kind and vector registers select.
- R3: Status bits (index 2) are: bit0 read ok, bit1 read fail, bit2 fill ok, bit3 fill fail, bit4 copy ok, bit5 copy fail, bit6 interrupt raised, bit7 source invalid, bit8 destination invalid. Writing ones clears those bits and leaves the others unchanged.
- R4: An address is invalid when it is zero or when its two low bits are not 00. Read and copy check the source, and fill and copy check the destination. An invalid address sets the matching invalid flag and the operation's fail bit, and no memory request is issued. Every issued request carries a nonzero, word-aligned address.
- R5: A fill writes ceil(size/4) words to destination + 4*i. Word i carries the scratch value plus i, using the scratch value held when the command started.
- R6: A read issues ceil(size/4) read requests to source + 4*i. At most one request is outstanding, and a stalled request holds its address.
- R7: A copy reads word i from source + 4*i and writes it to destination + 4*i, for every word in turn.
- R8: A size of zero with valid addresses sets the success bit at once, and no request is issued.
- R9: An error response ends the operation, sets its fail bit and issues no further requests.
- R10: When an action ends, a one-cycle interrupt request carries the kind and vector registers. Status bit6 is set on the cycle after that request.
- R11: Kind 0 (legacy) accepts vector 0 only, kind 1 (MSI) accepts 1 to 32, and kind 2 (MSI-X) accepts 1 to 2048. Any other kind or vector suppresses the request and leaves bit6 clear.
- R12: The command register reads zero once the engine takes the command. A command written while an action is pending or running is ignored.
- R13: After reset, the scratch, command and status registers read zero, and no request or interrupt is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Memory request byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rsp_rdata | input | 32 | Response read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_kind | output | 2 | Interrupt kind: 0 legacy, 1 MSI, 2 MSI-X |
| irq_vec | output | VEC_W | Interrupt vector number |

## Verification
A wrong word counter or a wrong phase flag shows up on the memory port within the same operation. It appears as a missing, extra or misaddressed request, or as wrong write data, and the write queue catches it on the cycle the request is accepted. A corrupted engine state, or a wrong range decision on the vector, shows as an interrupt pulse that is missing, unexpected or mislabelled, two cycles after the last response. Status flags become visible to the next register read after the operation ends. A stuck command register shows as an ignored command or an extra operation, which the request count reveals.

// File: rtl/ept_pkg.sv
package ept_pkg;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 6;
  localparam int ST_W   = 9;
  localparam int REG_AW = 3;

  // command bit positions
  localparam int C_RAISE_LEG  = 0;
  localparam int C_RAISE_MSI  = 1;
  localparam int C_RAISE_MSIX = 2;
  localparam int C_RD         = 3;
  localparam int C_WR         = 4;
  localparam int C_CP         = 5;

  // status bit positions
  localparam int S_RD_OK   = 0;
  localparam int S_RD_BAD  = 1;
  localparam int S_WR_OK   = 2;
  localparam int S_WR_BAD  = 3;
  localparam int S_CP_OK   = 4;
  localparam int S_CP_BAD  = 5;
  localparam int S_RAISED  = 6;
  localparam int S_SRC_INV = 7;
  localparam int S_DST_INV = 8;

  // register word indices
  localparam logic [REG_AW-1:0] RA_SCRATCH = 3'd0;
  localparam logic [REG_AW-1:0] RA_CMD     = 3'd1;
  localparam logic [REG_AW-1:0] RA_STATUS  = 3'd2;
  localparam logic [REG_AW-1:0] RA_SRC     = 3'd3;
  localparam logic [REG_AW-1:0] RA_DST     = 3'd4;
  localparam logic [REG_AW-1:0] RA_SIZE    = 3'd5;
  localparam logic [REG_AW-1:0] RA_KIND    = 3'd6;
  localparam logic [REG_AW-1:0] RA_VEC     = 3'd7;

  typedef enum logic [1:0] {IRQ_LEGACY = 2'd0, IRQ_MSI = 2'd1, IRQ_MSIX = 2'd2} irq_kind_e;
  typedef enum logic [2:0] {OP_NONE, OP_RAISE, OP_RD, OP_WR, OP_CP} op_e;
  typedef enum logic [1:0] {EN_IDLE, EN_REQ, EN_WAIT, EN_IRQ} eng_state_e;

  // isolate the lowest set command bit
  function automatic logic [CMD_W-1:0] lowest_one(input logic [CMD_W-1:0] v);
    return v & (~v + CMD_W'(1));
  endfunction

  function automatic logic addr_usable(input logic [31:0] a);
    return (a[1:0] == 2'b00) && (a != 32'd0);
  endfunction

  function automatic logic [31:0] words_for(input logic [31:0] nbytes);
    return (nbytes + 32'd3) >> 2;
  endfunction

  function automatic logic vec_allowed(input logic [1:0] kind, input logic [31:0] num,
                                       input int msi_max, input int msix_max);
    case (kind)
      IRQ_LEGACY: return num == 32'd0;
      IRQ_MSI:    return (num >= 32'd1) && (num <= 32'(msi_max));
      IRQ_MSIX:   return (num >= 32'd1) && (num <= 32'(msix_max));
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] fill_word(input logic [31:0] seed, input logic [31:0] idx);
    return seed + idx;
  endfunction

  function automatic logic [ST_W-1:0] ok_mask(input op_e op);
    case (op)
      OP_RD:   return ST_W'(1) << S_RD_OK;
      OP_WR:   return ST_W'(1) << S_WR_OK;
      OP_CP:   return ST_W'(1) << S_CP_OK;
      default: return '0;
    endcase
  endfunction

  function automatic logic [ST_W-1:0] bad_mask(input op_e op);
    case (op)
      OP_RD:   return ST_W'(1) << S_RD_BAD;
      OP_WR:   return ST_W'(1) << S_WR_BAD;
      OP_CP:   return ST_W'(1) << S_CP_BAD;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ept_regs.sv
module ept_regs
  import ept_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int VEC_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                cmd_take,
  input  logic                eng_idle,
  input  logic [ST_W-1:0]     st_set,
  input  logic                irq_seen,
  output logic [DATA_W-1:0]   scratch_q,
  output logic [CMD_W-1:0]    cmd_q,
  output logic [ST_W-1:0]     status_q,
  output logic [ADDR_W-1:0]   src_q,
  output logic [ADDR_W-1:0]   dst_q,
  output logic [SIZE_W-1:0]   size_q,
  output logic [1:0]          kind_q,
  output logic [VEC_W-1:0]    vec_q
);
  logic            busy;
  logic [ST_W-1:0] clr_mask;
  logic [ST_W-1:0] set_mask;

  assign busy     = !eng_idle || (cmd_q != '0);
  assign clr_mask = (reg_we && reg_addr == RA_STATUS) ? reg_wdata[ST_W-1:0] : '0;
  assign set_mask = st_set | (ST_W'(irq_seen) << S_RAISED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      cmd_q     <= '0;
      status_q  <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      size_q    <= '0;
      kind_q    <= '0;
      vec_q     <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | set_mask;
      if (cmd_take) cmd_q <= '0;
      else if (reg_we && reg_addr == RA_CMD && !busy) cmd_q <= reg_wdata[CMD_W-1:0];
      if (reg_we) begin
        case (reg_addr)
          RA_SCRATCH: scratch_q <= reg_wdata;
          RA_SRC:     src_q     <= reg_wdata[ADDR_W-1:0];
          RA_DST:     dst_q     <= reg_wdata[ADDR_W-1:0];
          RA_SIZE:    size_q    <= reg_wdata[SIZE_W-1:0];
          RA_KIND:    kind_q    <= reg_wdata[1:0];
          RA_VEC:     vec_q     <= reg_wdata[VEC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_SCRATCH: reg_rdata = scratch_q;
      RA_CMD:     reg_rdata = DATA_W'(cmd_q);
      RA_STATUS:  reg_rdata = DATA_W'(status_q);
      RA_SRC:     reg_rdata = DATA_W'(src_q);
      RA_DST:     reg_rdata = DATA_W'(dst_q);
      RA_SIZE:    reg_rdata = DATA_W'(size_q);
      RA_KIND:    reg_rdata = DATA_W'(kind_q);
      default:    reg_rdata = DATA_W'(vec_q);
    endcase
  end
endmodule

// File: rtl/ept_engine.sv
module ept_engine
  import ept_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_pend,
  output logic              cmd_take,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [SIZE_W-1:0] xfer_size,
  input  logic [DATA_W-1:0] seed,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [ST_W-1:0]   st_set,
  output logic              irq_fire,
  output logic              eng_idle
);
  localparam int WCNT_W = SIZE_W - 1;

  eng_state_e        state_q, state_d;
  op_e               op_q, start_op;
  logic [ADDR_W-1:0] src_l, dst_l;
  logic [DATA_W-1:0] seed_l, hold_q;
  logic [WCNT_W-1:0] idx_q, nw_q, nw_start;
  logic              fetch_q;
  logic [CMD_W-1:0]  sel;
  logic              src_inv, dst_inv, last_word;

  assign sel      = lowest_one(cmd_pend);
  assign nw_start = WCNT_W'(words_for(32'(xfer_size)));

  always_comb begin
    if (sel[C_RD])      start_op = OP_RD;
    else if (sel[C_WR]) start_op = OP_WR;
    else if (sel[C_CP]) start_op = OP_CP;
    else if (sel[C_RAISE_LEG] || sel[C_RAISE_MSI] || sel[C_RAISE_MSIX]) start_op = OP_RAISE;
    else                start_op = OP_NONE;
  end

  assign src_inv   = (start_op == OP_RD || start_op == OP_CP) && !addr_usable(32'(src_addr));
  assign dst_inv   = (start_op == OP_WR || start_op == OP_CP) && !addr_usable(32'(dst_addr));
  assign last_word = (idx_q == nw_q - WCNT_W'(1));

  always_comb begin
    state_d  = state_q;
    st_set   = '0;
    cmd_take = 1'b0;
    case (state_q)
      EN_IDLE: begin
        if (cmd_pend != '0) begin
          cmd_take = 1'b1;
          if (start_op == OP_RAISE) begin
            state_d = EN_IRQ;
          end else if (src_inv || dst_inv) begin
            st_set  = bad_mask(start_op) | (ST_W'(src_inv) << S_SRC_INV)
                    | (ST_W'(dst_inv) << S_DST_INV);
            state_d = EN_IRQ;
          end else if (nw_start == '0) begin
            st_set  = ok_mask(start_op);
            state_d = EN_IRQ;
          end else begin
            state_d = EN_REQ;
          end
        end
      end
      EN_REQ: if (mem_req_ready) state_d = EN_WAIT;
      EN_WAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            st_set  = bad_mask(op_q);
            state_d = EN_IRQ;
          end else if (op_q == OP_CP && fetch_q) begin
            state_d = EN_REQ;
          end else if (last_word) begin
            st_set  = ok_mask(op_q);
            state_d = EN_IRQ;
          end else begin
            state_d = EN_REQ;
          end
        end
      end
      default: state_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EN_IDLE;
      op_q    <= OP_NONE;
      src_l   <= '0;
      dst_l   <= '0;
      seed_l  <= '0;
      hold_q  <= '0;
      idx_q   <= '0;
      nw_q    <= '0;
      fetch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == EN_IDLE && cmd_take) begin
        op_q    <= start_op;
        src_l   <= src_addr;
        dst_l   <= dst_addr;
        seed_l  <= seed;
        nw_q    <= nw_start;
        idx_q   <= '0;
        fetch_q <= (start_op == OP_RD) || (start_op == OP_CP);
      end else if (state_q == EN_WAIT && mem_rsp_valid && !mem_rsp_err) begin
        if (op_q == OP_CP && fetch_q) begin
          hold_q  <= mem_rsp_rdata;
          fetch_q <= 1'b0;
        end else if (!last_word) begin
          idx_q   <= idx_q + WCNT_W'(1);
          fetch_q <= (op_q != OP_WR);
        end
      end
    end
  end

  assign mem_req_valid = (state_q == EN_REQ);
  assign mem_req_write = !fetch_q;
  assign mem_req_addr  = (fetch_q ? src_l : dst_l) + ADDR_W'({idx_q, 2'b00});
  assign mem_req_wdata = (op_q == OP_WR) ? fill_word(seed_l, 32'(idx_q)) : hold_q;
  assign irq_fire      = (state_q == EN_IRQ);
  assign eng_idle      = (state_q == EN_IDLE);
endmodule

// File: rtl/ept_irq_gen.sv
module ept_irq_gen
  import ept_pkg::*;
#(
  parameter int VEC_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [1:0]       kind_in,
  input  logic [VEC_W-1:0] num_in,
  output logic             irq_valid,
  output logic [1:0]       irq_kind,
  output logic [VEC_W-1:0] irq_vec
);
  logic allowed;
  assign allowed = vec_allowed(kind_in, 32'(num_in), MSI_MAX, MSIX_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_kind  <= '0;
      irq_vec   <= '0;
    end else begin
      irq_valid <= fire && allowed;
      if (fire && allowed) begin
        irq_kind <= kind_in;
        irq_vec  <= num_in;
      end
    end
  end
endmodule

// File: rtl/ept_ctrl.sv
module ept_ctrl
  import ept_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 16,
  parameter int VEC_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              irq_valid,
  output logic [1:0]        irq_kind,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [DATA_W-1:0] scratch_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ST_W-1:0]   status_q, st_set;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [SIZE_W-1:0] size_q;
  logic [1:0]        kind_q;
  logic [VEC_W-1:0]  vec_q;
  logic              cmd_take, eng_idle, irq_fire;

  ept_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_take(cmd_take),
    .eng_idle(eng_idle), .st_set(st_set), .irq_seen(irq_valid),
    .scratch_q(scratch_q), .cmd_q(cmd_q), .status_q(status_q), .src_q(src_q),
    .dst_q(dst_q), .size_q(size_q), .kind_q(kind_q), .vec_q(vec_q)
  );

  ept_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .cmd_pend(cmd_q), .cmd_take(cmd_take),
    .src_addr(src_q), .dst_addr(dst_q), .xfer_size(size_q), .seed(scratch_q),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
    .st_set(st_set), .irq_fire(irq_fire), .eng_idle(eng_idle)
  );

  ept_irq_gen #(.VEC_W(VEC_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_irq (
    .clk(clk), .rst_n(rst_n), .fire(irq_fire), .kind_in(kind_q), .num_in(vec_q),
    .irq_valid(irq_valid), .irq_kind(irq_kind), .irq_vec(irq_vec)
  );
endmodule

// File: rtl/ept_ctrl_chk.sv
module ept_ctrl_chk #(
  parameter int ADDR_W   = 32,
  parameter int VEC_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              irq_valid,
  input logic [1:0]        irq_kind,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [8:0]        status_q,
  input logic [5:0]        cmd_q,
  input logic              eng_idle
);
  a_r4_req_addr_usable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00) && (mem_req_addr != '0));

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  a_r6_stall_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

  a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  a_r10_raised_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> status_q[6]);

  a_r11_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((irq_kind == 2'd0) && (irq_vec == '0))
               || ((irq_kind == 2'd1) && (32'(irq_vec) >= 32'd1) && (32'(irq_vec) <= 32'(MSI_MAX)))
               || ((irq_kind == 2'd2) && (32'(irq_vec) >= 32'd1) && (32'(irq_vec) <= 32'(MSIX_MAX))));

  a_r12_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_idle && cmd_q == '0) |=> (cmd_q == '0));
endmodule

bind ept_ctrl ept_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .irq_valid(irq_valid), .irq_kind(irq_kind), .irq_vec(irq_vec),
  .status_q(status_q), .cmd_q(cmd_q), .eng_idle(eng_idle)
);

// File: tb/ept_ctrl_bench.sv
`timescale 1ns/1ps
module ept_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write, mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_rdata;
  logic        irq_valid;
  logic [1:0]  irq_kind;
  logic [11:0] irq_vec;

  int n_tests = 0;
  int n_fail  = 0;
  int req_cnt = 0;
  bit finished = 0;
  bit stall_en = 0;
  logic [31:0] cyc = 0;
  logic [31:0] hmem [0:255];

  logic [1:0]  exp_kind_q [$];
  logic [11:0] exp_vec_q  [$];
  logic [31:0] exp_wa_q   [$];
  logic [31:0] exp_wd_q   [$];

  always #2 clk = ~clk;

  ept_ctrl u_ept_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
    .irq_valid(irq_valid), .irq_kind(irq_kind), .irq_vec(irq_vec)
  );

  // host memory model: one-cycle response, error above 0x8000
  assign mem_req_ready = !stall_en || cyc[0];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      mem_rsp_rdata <= 32'd0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_err   <= mem_req_addr[15];
      mem_rsp_rdata <= hmem[mem_req_addr[9:2]];
      if (mem_req_valid && mem_req_ready && mem_req_write && !mem_req_addr[15])
        hmem[mem_req_addr[9:2]] <= mem_req_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares interrupts and write requests against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_valid) begin
        if (exp_kind_q.size() == 0) begin
          chk("R11 unexpected interrupt", {18'd0, irq_kind, irq_vec}, 32'hFFFF_FFFF);
        end else begin
          chk("R10 interrupt kind", 32'(irq_kind), 32'(exp_kind_q.pop_front()));
          chk("R10 interrupt vector", 32'(irq_vec), 32'(exp_vec_q.pop_front()));
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        if (mem_req_write) begin
          if (exp_wa_q.size() == 0) begin
            chk("R5/R7 unexpected write", mem_req_addr, 32'hFFFF_FFFF);
          end else begin
            chk("R5/R7 write address", mem_req_addr, exp_wa_q.pop_front());
            chk("R5/R7 write data", mem_req_wdata, exp_wd_q.pop_front());
          end
        end
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic expect_irq(input logic [1:0] k, input logic [11:0] v);
    exp_kind_q.push_back(k);
    exp_vec_q.push_back(v);
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
    exp_wa_q.push_back(a);
    exp_wd_q.push_back(d);
  endtask

  // run a command, wait, then check status and request count
  task automatic run(input string tag, input logic [31:0] cmd, input logic [31:0] exp_status,
                     input int exp_reqs);
    logic [31:0] st;
    int base;
    base = req_cnt;
    reg_wr(3'd2, 32'h1FF);
    reg_wr(3'd1, cmd);
    repeat (80) @(negedge clk);
    reg_rd(3'd2, st);
    chk({tag, " status"}, st, exp_status);
    chk({tag, " request count"}, 32'(req_cnt - base), 32'(exp_reqs));
    chk("R10 interrupt queue drained", 32'(exp_kind_q.size()), 32'd0);
    chk("R5/R7 write queue drained", 32'(exp_wa_q.size()), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 256; i++) hmem[i] = 32'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    reg_rd(3'd0, rd); chk("R13 scratch after reset", rd, 32'd0);
    reg_rd(3'd1, rd); chk("R13 command after reset", rd, 32'd0);
    reg_rd(3'd2, rd); chk("R13 status after reset", rd, 32'd0);
    chk("R13 no irq after reset", 32'(irq_valid), 32'd0);
    chk("R13 no request after reset", 32'(mem_req_valid), 32'd0);

    // R1 scratch pattern
    reg_wr(3'd0, 32'hDEAD_BEEF); reg_rd(3'd0, rd); chk("R1 scratch pattern a", rd, 32'hDEAD_BEEF);
    reg_wr(3'd0, 32'h1234_0000); reg_rd(3'd0, rd); chk("R1 scratch pattern b", rd, 32'h1234_0000);

    reg_wr(3'd6, 32'd1); reg_wr(3'd7, 32'd1);

    // R5 fill 12 bytes at 0x100
    reg_wr(3'd4, 32'h100); reg_wr(3'd5, 32'd12);
    for (int i = 0; i < 3; i++) expect_wr(32'h100 + 4*i, 32'h1234_0000 + i);
    expect_irq(2'd1, 12'd1);
    run("R5 fill", 32'h10, 32'h044, 3);
    chk("R5 memory word 2", hmem[8'h42], 32'h1234_0002);

    // R6 read 5 bytes = 2 words
    reg_wr(3'd3, 32'h100); reg_wr(3'd5, 32'd5);
    expect_irq(2'd1, 12'd1);
    run("R6 read", 32'h08, 32'h041, 2);

    // R7 copy 10 bytes with stalls
    stall_en = 1;
    reg_wr(3'd4, 32'h200); reg_wr(3'd5, 32'd10);
    for (int i = 0; i < 3; i++) expect_wr(32'h200 + 4*i, 32'h1234_0000 + i);
    expect_irq(2'd1, 12'd1);
    run("R7 copy", 32'h20, 32'h050, 6);
    chk("R7 copied word 0", hmem[8'h80], 32'h1234_0000);
    stall_en = 0;

    // R4 unaligned source
    reg_wr(3'd3, 32'h102); reg_wr(3'd5, 32'd8);
    expect_irq(2'd1, 12'd1);
    run("R4 unaligned source", 32'h08, 32'h0C2, 0);

    // R4 zero destination on copy
    reg_wr(3'd3, 32'h100); reg_wr(3'd4, 32'h0);
    expect_irq(2'd1, 12'd1);
    run("R4 zero destination", 32'h20, 32'h160, 0);

    // R8 zero size
    reg_wr(3'd4, 32'h100); reg_wr(3'd5, 32'd0);
    expect_irq(2'd1, 12'd1);
    run("R8 zero size", 32'h10, 32'h044, 0);

    // R9 error response
    reg_wr(3'd3, 32'h8000); reg_wr(3'd5, 32'd8);
    expect_irq(2'd1, 12'd1);
    run("R9 error response", 32'h08, 32'h042, 1);

    // R2 raise MSI vector 5
    reg_wr(3'd7, 32'd5);
    expect_irq(2'd1, 12'd5);
    run("R2 raise", 32'h02, 32'h040, 0);

    // R11 vector ranges
    reg_wr(3'd7, 32'd33);
    run("R11 msi vector 33 rejected", 32'h02, 32'h000, 0);
    reg_wr(3'd6, 32'd0); reg_wr(3'd7, 32'd0);
    expect_irq(2'd0, 12'd0);
    run("R11 legacy vector 0", 32'h01, 32'h040, 0);
    reg_wr(3'd7, 32'd1);
    run("R11 legacy vector 1 rejected", 32'h01, 32'h000, 0);
    reg_wr(3'd6, 32'd2); reg_wr(3'd7, 32'd2048);
    expect_irq(2'd2, 12'd2048);
    run("R11 msix vector 2048", 32'h04, 32'h040, 0);
    reg_wr(3'd7, 32'd2049);
    run("R11 msix vector 2049 rejected", 32'h04, 32'h000, 0);
    reg_wr(3'd6, 32'd3); reg_wr(3'd7, 32'd1);
    run("R11 kind 3 rejected", 32'h04, 32'h000, 0);
    reg_wr(3'd6, 32'd1);

    // R2 several bits: read wins over fill
    reg_wr(3'd3, 32'h100); reg_wr(3'd4, 32'h300); reg_wr(3'd5, 32'd4);
    expect_irq(2'd1, 12'd1);
    run("R2 lowest bit wins", 32'h18, 32'h041, 1);

    // R12 busy: second command ignored, command self-clears
    reg_wr(3'd3, 32'h8000); reg_wr(3'd5, 32'd64);
    for (int i = 0; i < 16; i++) expect_wr(32'h300 + 4*i, 32'h1234_0000 + i);
    expect_irq(2'd1, 12'd1);
    begin
      int base;
      logic [31:0] st;
      base = req_cnt;
      reg_wr(3'd2, 32'h1FF);
      reg_wr(3'd1, 32'h10);
      repeat (3) @(negedge clk);
      reg_wr(3'd1, 32'h08);
      reg_rd(3'd1, rd); chk("R12 command reads zero", rd, 32'd0);
      repeat (80) @(negedge clk);
      reg_rd(3'd2, st); chk("R12 busy status", st, 32'h044);
      chk("R12 ignored command made no requests", 32'(req_cnt - base), 32'd16);
      chk("R10 interrupt queue drained", 32'(exp_kind_q.size()), 32'd0);
    end

    // R3 write-one-to-clear
    reg_wr(3'd2, 32'h004);
    reg_rd(3'd2, rd); chk("R3 partial clear", rd, 32'h040);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule